// File: doc/BRIEF.md
# Dual-Domain Reset Controller

This block turns a set of reset triggers into three active-high reset outputs, one for the processor core, one for the peripherals and one for an always-on backup domain, plus an open-drain pull-down enable for a shared bidirectional reset line. The triggers are a power-on indication, the bidirectional line itself, an input-only system reset line that carries a glitch filter, and a software reset request.

The bidirectional line and the software request reset only the core and the peripherals; the backup domain is left running. Either of them starts a pulse generator that pulls the bidirectional line low for a fixed number of slow-clock cycles, so that parts sharing the line always see a reset of a known width, however short the trigger was. The input-only line behaves like a power-on: once it has been seen low for enough consecutive samples, every output, the backup domain included, is held in reset until the line returns high. All outputs assert asynchronously and are released through a chain of flops clocked by the slow clock.

Top module: `dual_reset_ctrl`

## Requirements
- R1: While `por_i` is 1, `core_rst_o`, `periph_rst_o` and `bkup_rst_o` are 1 and `pin_drive_o` is 0.
- R2: Release is synchronous: after the last trigger of an output clears, `core_rst_o` and `bkup_rst_o` stay 1 for CORE_STAGES and BKUP_STAGES (default 2) further rising edges, and `periph_rst_o` for PERIPH_STAGES (default 3).
- R3: A low level on `ext_pin_n_i` of any width, including one shorter than a clock period, sets `core_rst_o` and `periph_rst_o` at once, without waiting for a clock edge, and starts a drive pulse.
- R4: Neither `ext_pin_n_i` nor `sw_req_i` ever sets `bkup_rst_o`.
- R5: Every drive pulse holds `pin_drive_o` at 1 for exactly 2^PW_LOG2 consecutive cycles; it begins one cycle after the trigger is taken.
- R6: A `sw_req_i` sampled at 1 on a rising edge while idle sets `core_rst_o` and `periph_rst_o` right after that edge and starts a drive pulse; core reset then lasts 2^PW_LOG2 + 4 cycles and peripheral reset 2^PW_LOG2 + 5 cycles, counted from that edge.
- R7: A `sw_req_i` that arrives while a drive pulse sequence is in progress is ignored: the pulse and the reset lengths are those of a single request.
- R8: When `sys_pin_n_i` is sampled low on FILT_LEN (default 3) consecutive edges after a two-flop input synchroniser, `bkup_rst_o`, `core_rst_o` and `periph_rst_o` are set; with the line going low just before edge 1, the backup reset appears right after edge FILT_LEN + 2 and not before, and `pin_drive_o` stays 0 meanwhile.
- R9: A low on `sys_pin_n_i` seen on fewer than FILT_LEN consecutive edges changes no output.
- R10: The backup, core and peripheral resets from `sys_pin_n_i` stay set while the line is low and are released, by the synchroniser chain of R2, after it returns high.
- R11: While `ext_pin_n_i` is held low from outside, `core_rst_o` stays 1 for the whole hold, across successive drive pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock for filtering, pulse timing and reset release |
| por_i | input | 1 | Power-on indication, active high |
| sys_pin_n_i | input | 1 | Input-only system reset line, active low, filtered |
| ext_pin_n_i | input | 1 | Level seen on the bidirectional reset line, active low |
| sw_req_i | input | 1 | Software reset request, sampled on rising edges |
| pin_drive_o | output | 1 | Open-drain enable: 1 pulls the bidirectional line low |
| core_rst_o | output | 1 | Core reset, active high |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| bkup_rst_o | output | 1 | Backup-domain reset, active high |

## Verification
The pulse path is driven by a software request, by a request repeated mid-pulse, by a sub-cycle external low pulse and by a long external hold; the first two tell a correctly ignored request from one that restarts the counter, the sub-cycle pulse separates an asynchronous capture from a sampled one, and the long hold shows that the controller's own drive does not lock itself out or drop the core reset between pulses. The input-only line is tried with a low of one sample fewer than the filter length and with a long low, which fixes both the rejection threshold and the exact edge at which the backup reset appears and is released. Every pulse test counts cycles of each output, so a wrong pulse width, a missing release stage or a backup reset leaking from the core triggers shows up as a count mismatch.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // States of the drive pulse sequencer
  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_ARM   = 2'd1,
    PG_DRIVE = 2'd2,
    PG_TAIL  = 2'd3
  } pg_state_e;

endpackage

// File: rtl/rstc_release_sync.sv
// Reset release chain: asserts as soon as src is high, releases after
// STAGES rising edges of clk once src is low.
module rstc_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic src,
  output logic rst_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge src) begin
    if (src) begin
      chain <= '1;
    end else begin
      chain <= {chain[STAGES-2:0], 1'b0};
    end
  end

  assign rst_o = chain[STAGES-1];

endmodule

// File: rtl/rstc_glitch_filter.sv
// Input synchroniser plus a run-length qualifier: qual_o rises once the
// synchronised line has been low for FILT_LEN consecutive samples.
module rstc_glitch_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  output logic qual_o
);

  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(FILT_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(FILT_LEN - 1);

  logic          meta_q;
  logic          sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      run_q  <= '0;
      qual_o <= 1'b0;
    end else begin
      meta_q <= pin_n;
      sync_q <= meta_q;
      if (sync_q) begin
        run_q  <= '0;
        qual_o <= 1'b0;
      end else begin
        if (run_q != RUN_MAX) begin
          run_q <= run_q + 1'b1;
        end
        if (run_q >= RUN_LAST) begin
          qual_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rstc_pulse_gen.sv
// Drive pulse sequencer: IDLE -> ARM (mask on) -> DRIVE (2**PW_LOG2 cycles)
// -> TAIL (mask still on) -> IDLE. Triggers are taken only in IDLE.
module rstc_pulse_gen
  import rstc_pkg::*;
#(
  parameter int unsigned PW_LOG2 = 6
) (
  input  logic clk,
  input  logic hard_rst,
  input  logic ext_trig,
  input  logic sw_req,
  output logic busy_o,
  output logic drive_o,
  output logic accept_o
);

  localparam int unsigned CW   = (PW_LOG2 < 1) ? 1 : PW_LOG2;
  localparam int unsigned PW   = 1 << PW_LOG2;
  localparam logic [CW-1:0] LAST = CW'(PW - 1);

  pg_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    accept_o = 1'b0;
    case (st_q)
      PG_IDLE: begin
        if (ext_trig || sw_req) begin
          st_n     = PG_ARM;
          accept_o = 1'b1;
        end
      end
      PG_ARM: begin
        st_n  = PG_DRIVE;
        cnt_n = '0;
      end
      PG_DRIVE: begin
        if (cnt_q == LAST) begin
          st_n = PG_TAIL;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      PG_TAIL: begin
        st_n = PG_IDLE;
      end
      default: begin
        st_n = PG_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst) begin
      st_q    <= PG_IDLE;
      cnt_q   <= '0;
      busy_o  <= 1'b0;
      drive_o <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      busy_o  <= (st_n != PG_IDLE);
      drive_o <= (st_n == PG_DRIVE);
    end
  end

endmodule

// File: rtl/dual_reset_ctrl.sv
module dual_reset_ctrl #(
  parameter int unsigned PW_LOG2       = 6,
  parameter int unsigned FILT_LEN      = 3,
  parameter int unsigned CORE_STAGES   = 2,
  parameter int unsigned PERIPH_STAGES = 3,
  parameter int unsigned BKUP_STAGES   = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic sys_pin_n_i,
  input  logic ext_pin_n_i,
  input  logic sw_req_i,
  output logic pin_drive_o,
  output logic core_rst_o,
  output logic periph_rst_o,
  output logic bkup_rst_o
);

  logic bkup_qual;
  logic hard_src;
  logic pg_busy;
  logic pg_accept;
  logic ext_low;
  logic ext_cap;
  logic core_src;

  // Input-only line: filtered, then treated like power-on
  rstc_glitch_filter #(
    .FILT_LEN(FILT_LEN)
  ) i_filter (
    .clk   (clk),
    .por   (por_i),
    .pin_n (sys_pin_n_i),
    .qual_o(bkup_qual)
  );

  assign hard_src = por_i | bkup_qual;

  // The line is ignored while the sequencer is busy, so that the block's
  // own drive does not retrigger it. busy rises a cycle before the drive
  // and falls a cycle after it, so the mask never races the line.
  assign ext_low = ~ext_pin_n_i & ~pg_busy;

  // Asynchronous capture: a low of any width sets the flag at once.
  always_ff @(posedge clk or posedge ext_low) begin
    if (ext_low) begin
      ext_cap <= 1'b1;
    end else if (pg_accept || bkup_rst_o) begin
      ext_cap <= 1'b0;
    end
  end

  rstc_pulse_gen #(
    .PW_LOG2(PW_LOG2)
  ) i_pulse (
    .clk     (clk),
    .hard_rst(hard_src),
    .ext_trig(ext_cap),
    .sw_req  (sw_req_i),
    .busy_o  (pg_busy),
    .drive_o (pin_drive_o),
    .accept_o(pg_accept)
  );

  assign core_src = hard_src | ext_cap | pg_busy;

  rstc_release_sync #(
    .STAGES(CORE_STAGES)
  ) i_core_sync (
    .clk  (clk),
    .src  (core_src),
    .rst_o(core_rst_o)
  );

  rstc_release_sync #(
    .STAGES(PERIPH_STAGES)
  ) i_periph_sync (
    .clk  (clk),
    .src  (core_src),
    .rst_o(periph_rst_o)
  );

  rstc_release_sync #(
    .STAGES(BKUP_STAGES)
  ) i_bkup_sync (
    .clk  (clk),
    .src  (hard_src),
    .rst_o(bkup_rst_o)
  );

endmodule

// File: rtl/dual_reset_ctrl_chk.sv
module dual_reset_ctrl_chk #(
  parameter int unsigned PW_LOG2 = 6
) (
  input logic clk,
  input logic por_i,
  input logic pin_drive_o,
  input logic core_rst_o,
  input logic periph_rst_o,
  input logic bkup_rst_o,
  input logic bkup_qual
);

  localparam int unsigned PW = 1 << PW_LOG2;

  // Count of consecutive samples with the drive on
  logic [16:0] drv_run;

  always_ff @(posedge clk) begin
    if (por_i) begin
      drv_run <= '0;
    end else if (pin_drive_o) begin
      drv_run <= drv_run + 17'd1;
    end else begin
      drv_run <= '0;
    end
  end

  // R1: power-on holds every reset and keeps the line released
  always @(negedge clk) begin
    if (por_i === 1'b1) begin
      p_por_all_r1: assert (core_rst_o && periph_rst_o && bkup_rst_o && !pin_drive_o);
    end
  end

  // R5: each drive pulse is exactly PW samples long
  p_pulse_width_r5: assert property (@(posedge clk) disable iff (por_i)
    $fell(pin_drive_o) |-> (drv_run == 17'(PW)));

  // R5: a pulse never runs past PW samples
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (por_i)
    pin_drive_o |-> (drv_run < 17'(PW)));

  // R6: core and peripherals are held while the line is driven
  p_core_during_drive_r6: assert property (@(posedge clk) disable iff (por_i)
    pin_drive_o |-> (core_rst_o && periph_rst_o));

  // R4: the backup reset rises only through the filtered input-only line
  p_bkup_source_r4: assert property (@(posedge clk) disable iff (por_i)
    $rose(bkup_rst_o) |-> bkup_qual);

  // R8: no drive while the input-only line is qualified
  p_no_drive_hard_r8: assert property (@(posedge clk) disable iff (por_i)
    bkup_qual |-> !pin_drive_o);

  // R10: a backup reset always comes with core and peripheral resets
  p_bkup_covers_core_r10: assert property (@(posedge clk) disable iff (por_i)
    bkup_rst_o |-> (core_rst_o && periph_rst_o));

endmodule

bind dual_reset_ctrl dual_reset_ctrl_chk #(
  .PW_LOG2(PW_LOG2)
) i_chk (
  .clk         (clk),
  .por_i       (por_i),
  .pin_drive_o (pin_drive_o),
  .core_rst_o  (core_rst_o),
  .periph_rst_o(periph_rst_o),
  .bkup_rst_o  (bkup_rst_o),
  .bkup_qual   (bkup_qual)
);

// File: tb/test_dual_reset_ctrl.sv
module test_dual_reset_ctrl;

  localparam int unsigned PW_LOG2 = 4;
  localparam int          PW      = 1 << PW_LOG2;
  localparam int unsigned FILT    = 3;

  logic clk = 1'b0;
  logic por_i = 1'b1;
  logic sys_pin_n = 1'b1;
  logic ext_force = 1'b0;
  logic sw_req = 1'b0;
  logic pin_drive, core_rst, periph_rst, bkup_rst;
  logic ext_pin_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // open-drain line: low if either side pulls it
  assign ext_pin_n = ~(pin_drive | ext_force);

  dual_reset_ctrl #(
    .PW_LOG2      (PW_LOG2),
    .FILT_LEN     (FILT),
    .CORE_STAGES  (2),
    .PERIPH_STAGES(3),
    .BKUP_STAGES  (2)
  ) i_dual_reset_ctrl (
    .clk         (clk),
    .por_i       (por_i),
    .sys_pin_n_i (sys_pin_n),
    .ext_pin_n_i (ext_pin_n),
    .sw_req_i    (sw_req),
    .pin_drive_o (pin_drive),
    .core_rst_o  (core_rst),
    .periph_rst_o(periph_rst),
    .bkup_rst_o  (bkup_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Samples n negedges starting with the current one; pulses sw_req once
  // at index poke (no pulse when poke < 0).
  task automatic measure(input int n, input int poke,
                         output int c_core, output int c_per,
                         output int c_drv, output int c_bk);
    c_core = 0; c_per = 0; c_drv = 0; c_bk = 0;
    for (int i = 0; i < n; i++) begin
      c_core += int'(core_rst);
      c_per  += int'(periph_rst);
      c_drv  += int'(pin_drive);
      c_bk   += int'(bkup_rst);
      sw_req = (i == poke);
      @(negedge clk);
    end
    sw_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(core_rst && periph_rst && bkup_rst, "R1 resets held", int'({core_rst, periph_rst, bkup_rst}), 7);
    chk(!pin_drive, "R1 no drive", int'(pin_drive), 0);
    por_i = 1'b0;
    @(negedge clk);
    chk(core_rst && bkup_rst, "R2 held one edge after release", int'({core_rst, bkup_rst}), 3);
    @(negedge clk);
    chk(!core_rst && !bkup_rst, "R2 core/bkup released", int'({core_rst, bkup_rst}), 0);
    chk(periph_rst, "R2 periph one stage later", int'(periph_rst), 1);
    @(negedge clk);
    chk(!periph_rst, "R2 periph released", int'(periph_rst), 0);
  endtask

  task automatic t_sw();
    int cc, cp, cd, cb;
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    chk(core_rst && periph_rst, "R6 immediate core reset", int'({core_rst, periph_rst}), 3);
    measure(PW + 12, -1, cc, cp, cd, cb);
    chk(cd == PW, "R5 sw drive width", cd, PW);
    chk(cc == PW + 4, "R6 core reset length", cc, PW + 4);
    chk(cp == PW + 5, "R6 periph reset length", cp, PW + 5);
    chk(cb == 0, "R4 sw leaves backup", cb, 0);
  endtask

  task automatic t_sw_busy();
    int cc, cp, cd, cb;
    sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0;
    measure(PW + 12, 6, cc, cp, cd, cb);
    chk(cd == PW, "R7 drive width with repeat request", cd, PW);
    chk(cc == PW + 4, "R7 core length with repeat request", cc, PW + 4);
    chk(cp == PW + 5, "R7 periph length with repeat request", cp, PW + 5);
  endtask

  task automatic t_ext_short();
    int cc, cp, cd, cb;
    #1 ext_force = 1'b1;
    #1 ext_force = 1'b0;
    #1;
    chk(core_rst && periph_rst, "R3 async assert on short pulse", int'({core_rst, periph_rst}), 3);
    @(negedge clk);
    measure(PW + 12, -1, cc, cp, cd, cb);
    chk(cd == PW, "R3 R5 short pulse stretched", cd, PW);
    chk(cc == PW + 4, "R3 core length after short pulse", cc, PW + 4);
    chk(cb == 0, "R4 ext leaves backup", cb, 0);
  endtask

  task automatic t_ext_hold();
    int gaps = 0;
    int bk = 0;
    ext_force = 1'b1;
    for (int i = 0; i < 3 * PW; i++) begin
      @(negedge clk);
      if (!core_rst) gaps++;
      if (bkup_rst) bk++;
    end
    chk(gaps == 0, "R11 core held through long low", gaps, 0);
    chk(bk == 0, "R4 long ext low leaves backup", bk, 0);
    ext_force = 1'b0;
    repeat (2 * PW + 10) @(negedge clk);
    chk(!core_rst && !periph_rst && !pin_drive, "R11 release after hold",
        int'({core_rst, periph_rst, pin_drive}), 0);
  endtask

  task automatic t_sys_glitch();
    int hits = 0;
    sys_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sys_pin_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bkup_rst || core_rst || periph_rst || pin_drive) hits++;
    end
    chk(hits == 0, "R9 short low rejected", hits, 0);
  endtask

  task automatic t_sys_long();
    sys_pin_n = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == FILT + 1) chk(!bkup_rst, "R8 not before filter length", int'(bkup_rst), 0);
      if (k == FILT + 2) chk(bkup_rst && core_rst && periph_rst, "R8 all resets set",
                             int'({bkup_rst, core_rst, periph_rst}), 7);
      if (k == 8) chk(bkup_rst && !pin_drive, "R10 held while low, no drive",
                      int'({bkup_rst, pin_drive}), 2);
    end
    sys_pin_n = 1'b1;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      if (j == 4) chk(bkup_rst && core_rst, "R10 still held before release",
                      int'({bkup_rst, core_rst}), 3);
      if (j == 5) chk(!bkup_rst && !core_rst && periph_rst, "R10 R2 synchronised release",
                      int'({bkup_rst, core_rst, periph_rst}), 1);
      if (j == 6) chk(!periph_rst, "R10 periph released", int'(periph_rst), 0);
    end
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_sw();
    t_sw_busy();
    t_ext_short();
    t_ext_hold();
    t_sys_glitch();
    t_sys_long();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

endmodule